// File: doc/BRIEF.md
# Discriminator Link Crossing Record Builder

This block sits behind the deserializer of a discriminator readout link. On every word clock it receives one 21-bit word: twenty discriminator bits, split into two 10-bit lanes (one per front-end module served by the link), and one frame marker bit. The marker is present once per beam crossing, on one word in seven. The block watches the spacing of the markers and declares alignment once the spacing has been regular for long enough. While aligned it gathers the seven words of each crossing into one record and writes it into an output FIFO.

Each record holds the two lanes as separate 70-bit sub-records and carries an 8-bit crossing sequence number. Records are produced back to back, one per crossing, with no dead time. A marker at the wrong spacing, or a missing marker, drops alignment, throws away the partial record and sets a sticky slip flag. A record that completes while the FIFO reports full is dropped and counted.

Top module: `disc_frame_aligner`

## Requirements
- R1: Input word layout: bit 20 is the frame marker, bits 19:10 are lane B (second module), bits 9:0 are lane A (first module).
- R2: `locked_o` rises in the cycle after the marker that completes the third consecutive spacing of exactly 7 words (the fourth regular marker). Before that no record is written.
- R3: While locked, the marker word is word 0 of a crossing. Word k of lane A is placed at record bits [10k+9:10k], word k of lane B at [70+10k+9:70+10k], and the sequence number at bits [147:140].
- R4: A record is written (`rec_valid_o` high for exactly one cycle) in the cycle after word 6 of a crossing is taken, only while locked; consecutive crossings give records exactly 7 cycles apart.
- R5: The sequence number of the first record after reset is 0 and steps by one for every completed record, including dropped ones, wrapping modulo 256.
- R6: If `fifo_full_i` is high while word 6 is presented, no record is written and `ovf_cnt_o` increases by one (saturating).
- R7: A marker whose distance from the previous marker is not 7 words clears `locked_o` in the next cycle, discards the partial record, and sets `slip_err_o`, which stays high until reset. That marker becomes the new reference for reacquisition.
- R8: A word without marker at the position where the next marker was due clears alignment and sets `slip_err_o`; acquisition restarts from the next marker, which needs three further regular spacings.
- R9: The first marker after reset, or after a missing marker, is not an error.
- R10: During and right after reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_i | input | 21 | Deserialized word: marker and two data lanes |
| fifo_full_i | input | 1 | Output FIFO cannot take a record |
| rec_valid_o | output | 1 | FIFO write strobe for one record |
| rec_data_o | output | 148 | Sequence number and both lane sub-records |
| locked_o | output | 1 | Frame alignment held |
| slip_err_o | output | 1 | Sticky framing slip flag |
| ovf_cnt_o | output | 16 | Records dropped on a full FIFO |

## Verification
The assertions assume `word_i` and `fifo_full_i` are steady across each rising clock edge and that reset holds long enough to settle every register, so that a locked rise can be traced to a marker word one cycle earlier. The bench changes inputs only on the falling edge and keeps `word_i` at zero throughout reset. It builds marker streams cycle by cycle so that each slip or missing marker falls at one deliberate word position, and it keeps the FIFO full for exactly one whole crossing.

// File: rtl/disc_frame_aligner.sv
module disc_frame_aligner #(
  parameter int LANE_W = 10,
  parameter int WORDS = 7,
  parameter int LOCK_SPACINGS = 3,
  parameter int SEQ_W = 8,
  parameter int OVF_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic [2*LANE_W:0] word_i,
  input  logic fifo_full_i,
  output logic rec_valid_o,
  output logic [2*LANE_W*WORDS+SEQ_W-1:0] rec_data_o,
  output logic locked_o,
  output logic slip_err_o,
  output logic [OVF_W-1:0] ovf_cnt_o
);
  localparam int WORD_W = 2*LANE_W + 1;
  localparam int SUB_W = LANE_W*WORDS;
  localparam int REC_W = 2*SUB_W + SEQ_W;
  localparam int GAP_W = $clog2(WORDS);
  localparam int LCK_W = $clog2(LOCK_SPACINGS + 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(WORDS - 1);
  localparam logic [GAP_W-1:0] GAP_PRE = GAP_W'(WORDS - 2);
  localparam logic [LCK_W-1:0] GOOD_LAST = LCK_W'(LOCK_SPACINGS - 1);

  logic [GAP_W-1:0] gap_q;
  logic seen_q, locked_q, err_q, valid_q;
  logic [LCK_W-1:0] good_q;
  logic [SUB_W-1:0] buf_a, buf_b;
  logic [SEQ_W-1:0] seq_q;
  logic [OVF_W-1:0] ovf_q;
  logic [REC_W-1:0] data_q;

  wire frame = word_i[WORD_W-1];
  wire [LANE_W-1:0] lane_a = word_i[LANE_W-1:0];
  wire [LANE_W-1:0] lane_b = word_i[2*LANE_W-1:LANE_W];
  wire spacing_ok = seen_q && (gap_q == GAP_LAST);
  wire bad_mark = frame && seen_q && !spacing_ok;
  wire missing = !frame && spacing_ok;
  wire lock_now = frame && spacing_ok && !locked_q && (good_q == GOOD_LAST);
  wire capture = (locked_q && !bad_mark && !missing) || lock_now;
  wire [GAP_W-1:0] slot = frame ? '0 : gap_q + 1'b1;
  wire last_word = locked_q && !frame && (gap_q == GAP_PRE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q <= '0;
      seen_q <= 1'b0;
      good_q <= '0;
      locked_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (frame) gap_q <= '0;
      else if (gap_q != GAP_LAST) gap_q <= gap_q + 1'b1;
      if (frame) seen_q <= 1'b1;
      else if (missing) seen_q <= 1'b0;
      if (frame) good_q <= (spacing_ok && good_q != LCK_W'(LOCK_SPACINGS)) ? good_q + 1'b1
                          : (spacing_ok ? good_q : '0);
      else if (missing) good_q <= '0;
      if (bad_mark || missing) begin
        locked_q <= 1'b0;
        err_q <= 1'b1;
      end else if (lock_now) locked_q <= 1'b1;
    end
  end

  for (genvar k = 0; k < WORDS; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        buf_a[k*LANE_W +: LANE_W] <= '0;
        buf_b[k*LANE_W +: LANE_W] <= '0;
      end else if (capture && slot == GAP_W'(k)) begin
        buf_a[k*LANE_W +: LANE_W] <= lane_a;
        buf_b[k*LANE_W +: LANE_W] <= lane_b;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q <= '0;
      seq_q <= '0;
      ovf_q <= '0;
    end else begin
      valid_q <= 1'b0;
      if (last_word) begin
        seq_q <= seq_q + 1'b1;
        if (fifo_full_i) begin
          if (ovf_q != '1) ovf_q <= ovf_q + 1'b1;
        end else begin
          valid_q <= 1'b1;
          data_q <= {seq_q,
                     lane_b, buf_b[SUB_W-LANE_W-1:0],
                     lane_a, buf_a[SUB_W-LANE_W-1:0]};
        end
      end
    end
  end

  assign rec_valid_o = valid_q;
  assign rec_data_o = data_q;
  assign locked_o = locked_q;
  assign slip_err_o = err_q;
  assign ovf_cnt_o = ovf_q;

  a_r4_valid_locked: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid_o |-> locked_o);
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid_o |=> !rec_valid_o);
  a_r6_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid_o |-> !$past(fifo_full_i));
  a_r6_ovf_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_cnt_o != $past(ovf_cnt_o)) |-> (ovf_cnt_o == OVF_W'($past(ovf_cnt_o) + 1'b1)));
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    slip_err_o |=> slip_err_o);
  a_r7_loss_flags: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked_o) |-> slip_err_o);
  a_r2_lock_on_marker: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> $past(word_i[WORD_W-1]));
endmodule

// File: tb/disc_frame_aligner_tb_top.sv
`timescale 1ns/1ps
module disc_frame_aligner_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [20:0] word_i = '0;
  logic fifo_full_i = 1'b0;
  logic rec_valid_o, locked_o, slip_err_o;
  logic [147:0] rec_data_o;
  logic [15:0] ovf_cnt_o;

  int checks = 0, errors = 0, nrec = 0, cyc = 0;
  logic [147:0] recs [64];
  int rec_t [64];
  bit done = 0;

  always #2.5 clk = ~clk;

  disc_frame_aligner dut_i (
    .clk(clk), .rst_n(rst_n), .word_i(word_i), .fifo_full_i(fifo_full_i),
    .rec_valid_o(rec_valid_o), .rec_data_o(rec_data_o), .locked_o(locked_o),
    .slip_err_o(slip_err_o), .ovf_cnt_o(ovf_cnt_o));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    if (rec_valid_o && nrec < 64) begin
      recs[nrec] = rec_data_o;
      rec_t[nrec] = cyc;
      nrec++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [147:0] act, input logic [147:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] lane_val(input int c, input int k);
    logic [6:0] cc = 7'(c);
    logic [2:0] kk = 3'(k);
    return {cc, kk};
  endfunction

  function automatic logic [20:0] wd(input int c, input int k, input bit mark);
    logic [9:0] a = lane_val(c, k);
    return {mark, a ^ 10'h3FF, a};
  endfunction

  function automatic logic [147:0] exp_rec(input int c, input int seq);
    logic [147:0] r = '0;
    for (int k = 0; k < 7; k++) begin
      r[10*k +: 10] = lane_val(c, k);
      r[70 + 10*k +: 10] = lane_val(c, k) ^ 10'h3FF;
    end
    r[147:140] = 8'(seq);
    return r;
  endfunction

  task automatic send_word(input logic [20:0] w, input bit full);
    @(negedge clk);
    word_i = w;
    fifo_full_i = full;
    @(posedge clk);
    #1.5;
  endtask

  task automatic send_cross(input int c, input bit full);
    for (int k = 0; k < 7; k++) send_word(wd(c, k, k == 0), full);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    word_i = '0;
    fifo_full_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk);
    #1.5;
  endtask

  int es = 0;

  task automatic t_reset();
    do_reset();
    chk(!rec_valid_o && !locked_o && !slip_err_o, "R10 flags", {rec_valid_o, locked_o, slip_err_o}, 0);
    chk(rec_data_o == 0 && ovf_cnt_o == 0, "R10 data", rec_data_o, 0);
  endtask

  task automatic t_lock();
    int n0 = nrec;
    for (int c = 0; c < 3; c++) send_cross(c, 0);
    chk(!locked_o, "R2 early", locked_o, 0);
    chk(nrec == n0, "R2 no record", nrec, n0);
    chk(!slip_err_o, "R9 first marker", slip_err_o, 0);
    send_word(wd(3, 0, 1), 0);
    chk(locked_o, "R2 lock", locked_o, 1);
    for (int k = 1; k < 6; k++) send_word(wd(3, k, 0), 0);
    chk(nrec == n0, "R4 not before word 6", nrec, n0);
    send_word(wd(3, 6, 0), 0);
    chk(nrec == n0 + 1, "R4 record written", nrec, n0 + 1);
    chk(recs[n0] == exp_rec(3, es), "R3 R1 R5 first record", recs[n0], exp_rec(3, es));
    es++;
  endtask

  task automatic t_stream();
    int n0 = nrec;
    for (int c = 4; c < 7; c++) send_cross(c, 0);
    chk(nrec == n0 + 3, "R4 stream count", nrec, n0 + 3);
    for (int i = 0; i < 3; i++) begin
      chk(recs[n0 + i] == exp_rec(4 + i, es), "R3 R5 stream record", recs[n0 + i], exp_rec(4 + i, es));
      es++;
      chk(rec_t[n0 + i] - rec_t[n0 + i - 1] == 7, "R4 spacing", rec_t[n0 + i] - rec_t[n0 + i - 1], 7);
    end
  endtask

  task automatic t_overflow();
    int n0 = nrec;
    send_cross(7, 1);
    chk(nrec == n0, "R6 dropped", nrec, n0);
    chk(ovf_cnt_o == 1, "R6 counter", ovf_cnt_o, 1);
    es++;
    send_cross(8, 0);
    chk(nrec == n0 + 1, "R6 resumes", nrec, n0 + 1);
    chk(recs[n0] == exp_rec(8, es), "R5 seq counts dropped", recs[n0], exp_rec(8, es));
    es++;
  endtask

  task automatic t_slip();
    int n0 = nrec;
    for (int k = 0; k < 3; k++) send_word(wd(9, k, k == 0), 0);
    send_word(wd(10, 0, 1), 0);
    chk(!locked_o, "R7 lock cleared", locked_o, 0);
    chk(slip_err_o, "R7 error set", slip_err_o, 1);
    for (int k = 1; k < 7; k++) send_word(wd(10, k, 0), 0);
    chk(nrec == n0, "R7 partial discarded", nrec, n0);
    send_cross(11, 0);
    send_cross(12, 0);
    chk(!locked_o, "R7 not yet relocked", locked_o, 0);
    send_cross(13, 0);
    chk(locked_o, "R7 relocked", locked_o, 1);
    chk(nrec == n0 + 1 && recs[n0] == exp_rec(13, es), "R7 relock record", recs[n0], exp_rec(13, es));
    es++;
    chk(slip_err_o, "R7 sticky", slip_err_o, 1);
  endtask

  task automatic t_missing();
    int n0;
    do_reset();
    es = 0;
    for (int c = 0; c < 4; c++) send_cross(c, 0);
    chk(locked_o && !slip_err_o, "R2 R9 locked again", {locked_o, slip_err_o}, 2'b10);
    send_word(wd(30, 1, 0), 0);
    chk(!locked_o, "R8 lock cleared", locked_o, 0);
    chk(slip_err_o, "R8 error set", slip_err_o, 1);
    n0 = nrec;
    for (int c = 20; c < 23; c++) send_cross(c, 0);
    chk(!locked_o, "R8 restart needs spacings", locked_o, 0);
    send_cross(23, 0);
    chk(locked_o && nrec == n0 + 1, "R8 relock", nrec, n0 + 1);
    chk(recs[n0] == exp_rec(23, 1), "R8 R5 record after relock", recs[n0], exp_rec(23, 1));
  endtask

  initial begin
    t_reset();
    t_lock();
    t_stream();
    t_overflow();
    t_slip();
    t_missing();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule